// File: doc/BRIEF.md
# Triggered Pattern Output Controller

This block drives a 16-bit output port from a staged pattern. Software loads the next pattern into two next-data bytes and chooses, with a per-bit enable mask, which output bits take part. When a selected timer compare-match pulse arrives, each enabled bit copies its staged value into the port data register. The port then drives the new value. Bits whose enable is clear keep their current value. The port is organised as four 4-bit groups, and the low byte and the high byte each have their own trigger.

Four single-cycle event inputs are available. A trigger-select register holds a 2-bit field for each byte half, and that field picks which event loads the half. All registers sit on a byte-wide bus with a one-cycle write and a combinational read. A standby input blocks transfers but keeps every register, including the enable masks, unchanged.

Top module: `trig_pattern_out`

## Requirements
- R1: After reset all seven registers read 0x00 and the port output is 0x0000.
- R2: A write at offset 0 (low next-data), 1 (high next-data), 2 (low enable), 3 (high enable), 4 (trigger select), 5 (low port data) or 6 (high port data) is read back at the same offset from the next cycle. Only bits 3..0 of offset 4 are stored; bits 7..4 read as 0. Offset 7 reads 0.
- R3: When the event selected for a half pulses, every enabled bit of that half takes its next-data value on port_out in the following cycle. The values used are the next-data and enable values held before any write in the same cycle.
- R4: A bit whose enable is 0 receives no transfer on an event and keeps its output value.
- R5: Trigger-select bits 1..0 choose the event index that loads port bits 7..0, and bits 3..2 choose the event index that loads bits 15..8. Pulses on events that are not selected have no effect on port_out.
- R6: If a write to a port data offset lands in the same cycle as that half's trigger, enabled bits take the next-data value and disabled bits take the written value.
- R7: While standby is 1, event pulses cause no transfer. All register contents, including both enable masks, are retained.
- R8: A write to offset 5 or 6 without a trigger sets the matching port byte on port_out in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Blocks transfers; keeps all registers |
| events | input | 4 | Compare-match pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| port_out | output | 16 | Port data register driving the pins |

## Verification
Directed patterns come first: complementary next-data and enable masks, so that loaded bits and held bits differ in every position. Events are then pulsed one by one, so a crossed select or a half triggered by the wrong source shows up. Collisions between a trigger and a port write, and trigger and next-data writes in the same cycle, separate write-wins from trigger-wins logic and show whether old or new staged values are used. A long random phase mixes writes, events and standby, and a behavioural model is compared with rdata and port_out on every clock.

// File: rtl/trig_pattern_out.sv
module trig_pattern_out #(
  parameter int NEV  = 4,
  parameter int SELW = $clog2(NEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic [NEV-1:0]   events,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [15:0]      port_out
);
  logic [7:0] nd_lo, nd_hi, en_lo, en_hi, pd_lo, pd_hi;
  logic [2*SELW-1:0] sel;

  wire trig_lo = events[sel[SELW-1:0]] & ~standby;
  wire trig_hi = events[sel[2*SELW-1:SELW]] & ~standby;
  wire [7:0] ld_lo = {8{trig_lo}} & en_lo;
  wire [7:0] ld_hi = {8{trig_hi}} & en_hi;
  wire [7:0] sw_lo = (wr_en && addr == 3'd5) ? wdata : pd_lo;
  wire [7:0] sw_hi = (wr_en && addr == 3'd6) ? wdata : pd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nd_lo <= '0; nd_hi <= '0; en_lo <= '0; en_hi <= '0;
      pd_lo <= '0; pd_hi <= '0; sel <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          3'd0: nd_lo <= wdata;
          3'd1: nd_hi <= wdata;
          3'd2: en_lo <= wdata;
          3'd3: en_hi <= wdata;
          3'd4: sel   <= wdata[2*SELW-1:0];
          default: ;
        endcase
      end
      pd_lo <= (ld_lo & nd_lo) | (~ld_lo & sw_lo);
      pd_hi <= (ld_hi & nd_hi) | (~ld_hi & sw_hi);
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = nd_lo;
      3'd1: rdata = nd_hi;
      3'd2: rdata = en_lo;
      3'd3: rdata = en_hi;
      3'd4: rdata = 8'(sel);
      3'd5: rdata = pd_lo;
      3'd6: rdata = pd_hi;
      default: rdata = 8'h00;
    endcase
  end

  assign port_out = {pd_hi, pd_lo};
endmodule

module trig_pattern_out_chk #(
  parameter int NEV  = 4,
  parameter int SELW = $clog2(NEV)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic [NEV-1:0]   events,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [7:0]       wdata,
  input logic [15:0]      port_out,
  input logic [15:0]      en,
  input logic [15:0]      nd,
  input logic [2*SELW-1:0] sel
);
  logic t_lo, t_hi, pw_lo, pw_hi;
  assign t_lo  = events[sel[SELW-1:0]] && !standby;
  assign t_hi  = events[sel[2*SELW-1:SELW]] && !standby;
  assign pw_lo = wr_en && addr == 3'd5;
  assign pw_hi = wr_en && addr == 3'd6;

  a_r3_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    t_lo |=> (port_out[7:0] & $past(en[7:0])) == ($past(nd[7:0]) & $past(en[7:0])));
  a_r3_high_load: assert property (@(posedge clk) disable iff (!rst_n)
    t_hi |=> (port_out[15:8] & $past(en[15:8])) == ($past(nd[15:8]) & $past(en[15:8])));
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pw_lo && !pw_hi) |=> ((port_out ^ $past(port_out)) & ~$past(en)) == 16'h0);
  a_r7_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !pw_lo && !pw_hi) |=> $stable(port_out));
  a_r8_sw_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_lo && !t_lo) |=> port_out[7:0] == $past(wdata));
endmodule

bind trig_pattern_out trig_pattern_out_chk #(.NEV(NEV), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .events(events),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .port_out(port_out),
  .en({en_hi, en_lo}), .nd({nd_hi, nd_lo}), .sel(sel)
);

// File: tb/tb_trig_pattern_out.sv
module tb_trig_pattern_out;
  logic clk = 0, rst_n = 0, standby = 0, wr_en = 0;
  logic [3:0] events = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [15:0] port_out;
  int n_run = 0, n_fail = 0, cyc = 0;
  string req = "R1";
  logic [7:0] m [0:7];

  always #2 clk = ~clk;

  trig_pattern_out dut (.clk(clk), .rst_n(rst_n), .standby(standby), .events(events),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .port_out(port_out));

  // behavioural reference: m[0..6] mirror the register map, m[7] stays 0
  always @(posedge clk) begin
    logic tl, th;
    logic [7:0] nl, nh;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m[i] <= 8'h00;
    end else begin
      tl = events[m[4] & 3] && !standby;
      th = events[(m[4] >> 2) & 3] && !standby;
      nl = m[5]; nh = m[6];
      if (wr_en && addr == 5) nl = wdata;
      if (wr_en && addr == 6) nh = wdata;
      for (int b = 0; b < 8; b++) begin
        if (tl && m[2][b]) nl[b] = m[0][b];
        if (th && m[3][b]) nh[b] = m[1][b];
      end
      m[5] <= nl; m[6] <= nh;
      if (wr_en && addr <= 3) m[addr] <= wdata;
      if (wr_en && addr == 4) m[4] <= wdata & 8'h0F;
    end
  end

  task automatic check(input [15:0] act, input [15:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(port_out, {m[6], m[5]}, "port_out");
      check({8'h0, rdata}, {8'h0, m[addr]}, "rdata");
    end
    if (cyc > 50000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input [2:0] a, input [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask
  task automatic pulse(input int e);
    @(negedge clk); events = 4'b1 << e;
    @(negedge clk); events = 0;
  endtask
  task automatic readall;
    for (int a = 0; a < 8; a++) begin @(negedge clk); addr = 3'(a); end
    @(negedge clk); addr = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    req = "R1";
    check(port_out, 16'h0000, "reset port");
    readall();
    req = "R2";
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'h0F); wr(3, 8'hF0); wr(4, 8'hF4);
    readall();
    check(port_out, 16'h0000, "no trigger yet");
    req = "R3"; pulse(0);
    check(port_out, 16'h0005, "low load ev0");
    req = "R5"; pulse(1);
    check(port_out, 16'h3005, "high load ev1");
    req = "R5"; wr(0, 8'h5A); wr(1, 8'hC3); pulse(2); pulse(3);
    check(port_out, 16'h3005, "unselected events");
    req = "R4"; wr(2, 8'hF0); pulse(0);
    check(port_out, 16'h3055, "disabled low bits held");
    req = "R8"; wr(5, 8'h81); wr(6, 8'h7E);
    check(port_out, 16'h7E81, "software write");
    req = "R6";
    @(negedge clk); wr_en = 1; addr = 5; wdata = 8'h0F; events = 4'b0001;
    @(negedge clk); wr_en = 0; events = 0;
    check(port_out, 16'h7E5F, "collision low");
    req = "R3";
    @(negedge clk); wr_en = 1; addr = 1; wdata = 8'hFF; events = 4'b0010;
    @(negedge clk); wr_en = 0; events = 0;
    check(port_out, 16'hCE5F, "old next-data used");
    req = "R7"; standby = 1; pulse(0); pulse(1); readall();
    check(port_out, 16'hCE5F, "standby blocks");
    standby = 0;
    req = "R2"; readall();
    req = "R5";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      addr = 3'($urandom);
      wdata = 8'($urandom);
      events = 4'($urandom) & 4'($urandom);
      standby = ($urandom % 8) == 0;
    end
    @(negedge clk); wr_en = 0; events = 0; standby = 0;
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule